// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator with Pair Fusion

The block generates eight pulse-width modulated outputs, one per 8-bit channel. Each channel has its own period and duty byte. Each channel also has its own choice of edge-aligned (left) or symmetric (center) counting. Neighbouring channels 2k and 2k+1 can be fused into one 16-bit channel. In that case the even channel carries the upper byte of the period, duty and counter, and the odd channel carries the lower byte. The fused channel drives the odd pin only.

Counters advance on clock cycles in which the `tick_i` clock enable is high. Software programs the block through a flat byte register file with a write strobe and a combinational read port. New period, duty and alignment values are held in per-channel shadow registers. They reach a running counter only at the end of its period, so a waveform never carries a truncated or doubled pulse.

Top module: `pwm_octet`

## Requirements
- R1: After reset every register reads 0 and every output pin is low.
- R2: Register addresses are: 0x00 enable (bit n = channel n), 0x01 alignment (bit n = 1 center, 0 left), 0x02 fusion control, 0x08+n period of channel n, 0x10+n duty of channel n, 0x18+n counter of channel n (read only). In the fusion control byte, bit 7 fuses pair 6/7, bit 6 fuses 4/5, bit 5 fuses 2/3 and bit 4 fuses 0/1. Bits 3:0 read 0. Writes take effect at the clock edge on which `wr_en_i` is high.
- R3: In left mode with period P>0, the counter runs 0..P-1 and wraps, so one cycle of the waveform is P ticks. The pin is high while the count is below duty D.
- R4: In center mode with period P>0, the counter runs 0 up to P and back down to 1, so one cycle of the waveform is 2P ticks. The pin is high while the count is below D, which gives 2D-1 high ticks per cycle when 0<D<P.
- R5: A duty of 0 holds the pin low. A duty greater than or equal to the period holds the pin high while the channel is enabled.
- R6: A disabled channel drives its pin low and reads a counter of 0.
- R7: In a fused pair, the period and duty are {even byte, odd byte}. The odd channel's enable and alignment bits govern the pair. The odd pin carries the waveform and the even pin stays low.
- R8: In a fused pair, the even channel's counter address returns the upper counter byte and the odd channel's address returns the lower byte.
- R9: Period, duty and alignment written while a channel runs take effect at the end of the current period. While the channel is disabled they take effect at once.
- R10: In cycles with `tick_i` low, counters hold and no output changes unless a register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (5) | Write address |
| wr_data_i | input | CW (8) | Write data |
| rd_addr_i | input | AW (5) | Read address |
| rd_data_o | output | CW (8) | Read data, combinational |
| pwm_o | output | NCH (8) | Modulated output pins |

## Verification
A counter stepping the wrong way or wrapping one tick late changes the number of high ticks within one waveform cycle. It also shifts the edges of the next cycle, so a window of two whole cycles exposes it within 2P or 4P ticks. A shadow register loading too early shows up as a wrong high count in the remainder of the period in which the write happened. Wrong steering in a fused pair shows up at once as activity on the even pin, or as a mismatch in the 16-bit counter bytes read back.

// File: rtl/pwm_octet_pkg.sv
package pwm_octet_pkg;
   localparam int ADDR_EN       = 'h00;
   localparam int ADDR_ALIGN    = 'h01;
   localparam int ADDR_FUSE     = 'h02;
   localparam int ADDR_PER_BASE = 'h08;
   localparam int ADDR_DTY_BASE = 'h10;
   localparam int ADDR_CNT_BASE = 'h18;

   typedef enum logic {
      ALIGN_LEFT   = 1'b0,
      ALIGN_CENTER = 1'b1
   } align_e;
endpackage

// File: rtl/pwm_octet_core.sv
module pwm_octet_core #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         run_i,
   input  logic         center_i,
   input  logic [W-1:0] per_i,
   input  logic [W-1:0] duty_i,
   output logic         pwm_o,
   output logic [W-1:0] cnt_o
);
   import pwm_octet_pkg::*;

   logic [W-1:0] cnt_q, cnt_d, cnt_dec;
   logic [W-1:0] per_q, duty_q;
   logic         down_q, down_d, load;
   align_e       mode_q;

   assign cnt_dec = cnt_q - 1'b1;

   always_comb begin
      cnt_d  = cnt_q;
      down_d = down_q;
      load   = 1'b0;
      if (per_q == '0) begin
         cnt_d  = '0;
         down_d = 1'b0;
         load   = 1'b1;
      end else if (mode_q == ALIGN_LEFT) begin
         if (cnt_q >= per_q - 1'b1) begin
            cnt_d = '0;
            load  = 1'b1;
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end else if (!down_q) begin
         if (cnt_q >= per_q) begin
            cnt_d  = cnt_dec;
            down_d = (cnt_dec != '0);
            load   = (cnt_dec == '0);
         end else begin
            cnt_d = cnt_q + 1'b1;
         end
      end else begin
         cnt_d = cnt_dec;
         if (cnt_dec == '0) begin
            down_d = 1'b0;
            load   = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
         per_q  <= '0;
         duty_q <= '0;
         mode_q <= ALIGN_LEFT;
      end else if (!run_i) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
         per_q  <= per_i;
         duty_q <= duty_i;
         mode_q <= align_e'(center_i);
      end else if (tick_i) begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
         if (load) begin
            per_q  <= per_i;
            duty_q <= duty_i;
            mode_q <= align_e'(center_i);
         end
      end
   end

   assign pwm_o = run_i && (duty_q != '0) && ((duty_q >= per_q) || (cnt_q < duty_q));
   assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_octet_pair.sv
module pwm_octet_pair #(
   parameter int CW     = 8,
   parameter bit CAT_EN = 1'b1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          tick_i,
   input  logic          fuse_i,
   input  logic          en_lo_i,
   input  logic          en_hi_i,
   input  logic          ctr_lo_i,
   input  logic          ctr_hi_i,
   input  logic [CW-1:0] per_lo_i,
   input  logic [CW-1:0] per_hi_i,
   input  logic [CW-1:0] dty_lo_i,
   input  logic [CW-1:0] dty_hi_i,
   output logic          pwm_lo_o,
   output logic          pwm_hi_o,
   output logic [CW-1:0] cnt_lo_o,
   output logic [CW-1:0] cnt_hi_o
);
   localparam int WW = 2 * CW;

   logic          fuse_eff;
   logic          n_lo_pwm, n_hi_pwm, w_pwm;
   logic [CW-1:0] n_lo_cnt, n_hi_cnt;
   logic [WW-1:0] w_cnt;

   assign fuse_eff = CAT_EN ? fuse_i : 1'b0;

   pwm_octet_core #(.W(CW)) u_lo (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
      .run_i(en_lo_i & ~fuse_eff), .center_i(ctr_lo_i),
      .per_i(per_lo_i), .duty_i(dty_lo_i),
      .pwm_o(n_lo_pwm), .cnt_o(n_lo_cnt)
   );

   pwm_octet_core #(.W(CW)) u_hi (
      .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
      .run_i(en_hi_i & ~fuse_eff), .center_i(ctr_hi_i),
      .per_i(per_hi_i), .duty_i(dty_hi_i),
      .pwm_o(n_hi_pwm), .cnt_o(n_hi_cnt)
   );

   generate
      if (CAT_EN) begin : g_wide
         pwm_octet_core #(.W(WW)) u_wide (
            .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
            .run_i(en_hi_i & fuse_eff), .center_i(ctr_hi_i),
            .per_i({per_lo_i, per_hi_i}), .duty_i({dty_lo_i, dty_hi_i}),
            .pwm_o(w_pwm), .cnt_o(w_cnt)
         );
      end else begin : g_no_wide
         assign w_pwm = 1'b0;
         assign w_cnt = '0;
      end
   endgenerate

   assign pwm_lo_o = fuse_eff ? 1'b0 : n_lo_pwm;
   assign pwm_hi_o = fuse_eff ? w_pwm : n_hi_pwm;
   assign cnt_lo_o = fuse_eff ? w_cnt[WW-1:CW] : n_lo_cnt;
   assign cnt_hi_o = fuse_eff ? w_cnt[CW-1:0] : n_hi_cnt;
endmodule

// File: rtl/pwm_octet_regs.sv
module pwm_octet_regs #(
   parameter int NCH    = 8,
   parameter int CW     = 8,
   parameter int AW     = 5,
   parameter bit CAT_EN = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_en_i,
   input  logic [AW-1:0]           wr_addr_i,
   input  logic [CW-1:0]           wr_data_i,
   input  logic [AW-1:0]           rd_addr_i,
   input  logic [NCH-1:0][CW-1:0]  cnt_i,
   output logic [CW-1:0]           rd_data_o,
   output logic [NCH-1:0]          en_o,
   output logic [NCH-1:0]          align_o,
   output logic [NCH-1:0]          fuse_o,
   output logic [NCH-1:0][CW-1:0]  per_o,
   output logic [NCH-1:0][CW-1:0]  dty_o
);
   import pwm_octet_pkg::*;

   localparam int NPAIR = NCH / 2;
   localparam logic [NCH-1:0] FUSE_MASK =
      CAT_EN ? {{NPAIR{1'b1}}, {(NCH - NPAIR){1'b0}}} : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o    <= '0;
         align_o <= '0;
         fuse_o  <= '0;
         per_o   <= '0;
         dty_o   <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == AW'(ADDR_EN))    en_o    <= wr_data_i[NCH-1:0];
         if (wr_addr_i == AW'(ADDR_ALIGN)) align_o <= wr_data_i[NCH-1:0];
         if (wr_addr_i == AW'(ADDR_FUSE))  fuse_o  <= wr_data_i[NCH-1:0] & FUSE_MASK;
         for (int i = 0; i < NCH; i++) begin
            if (wr_addr_i == AW'(ADDR_PER_BASE + i)) per_o[i] <= wr_data_i;
            if (wr_addr_i == AW'(ADDR_DTY_BASE + i)) dty_o[i] <= wr_data_i;
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == AW'(ADDR_EN))    rd_data_o = CW'(en_o);
      if (rd_addr_i == AW'(ADDR_ALIGN)) rd_data_o = CW'(align_o);
      if (rd_addr_i == AW'(ADDR_FUSE))  rd_data_o = CW'(fuse_o);
      for (int i = 0; i < NCH; i++) begin
         if (rd_addr_i == AW'(ADDR_PER_BASE + i)) rd_data_o = per_o[i];
         if (rd_addr_i == AW'(ADDR_DTY_BASE + i)) rd_data_o = dty_o[i];
         if (rd_addr_i == AW'(ADDR_CNT_BASE + i)) rd_data_o = cnt_i[i];
      end
   end
endmodule

// File: rtl/pwm_octet.sv
module pwm_octet #(
   parameter int NCH    = 8,
   parameter int CW     = 8,
   parameter int AW     = 5,
   parameter bit CAT_EN = 1'b1
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           tick_i,
   input  logic           wr_en_i,
   input  logic [AW-1:0]  wr_addr_i,
   input  logic [CW-1:0]  wr_data_i,
   input  logic [AW-1:0]  rd_addr_i,
   output logic [CW-1:0]  rd_data_o,
   output logic [NCH-1:0] pwm_o
);
   localparam int NPAIR = NCH / 2;

   generate
      if ((NCH % 2) != 0 || NCH < 2 || NCH > 8) begin : g_bad_nch
         initial $fatal(1, "pwm_octet: NCH must be even and within 2..8");
      end
      if (CW < NCH || CW < 2) begin : g_bad_cw
         initial $fatal(1, "pwm_octet: CW must cover one bit per channel");
      end
      if (AW < 5) begin : g_bad_aw
         initial $fatal(1, "pwm_octet: AW must reach the counter window");
      end
   endgenerate

   logic [NCH-1:0]         en_q, align_q, fuse_q;
   logic [NCH-1:0][CW-1:0] per_q, dty_q, cnt_w;

   pwm_octet_regs #(.NCH(NCH), .CW(CW), .AW(AW), .CAT_EN(CAT_EN)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .cnt_i(cnt_w), .rd_data_o(rd_data_o),
      .en_o(en_q), .align_o(align_q), .fuse_o(fuse_q),
      .per_o(per_q), .dty_o(dty_q)
   );

   generate
      for (genvar p = 0; p < NPAIR; p++) begin : g_pair
         pwm_octet_pair #(.CW(CW), .CAT_EN(CAT_EN)) u_pair (
            .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
            .fuse_i(fuse_q[NPAIR + p]),
            .en_lo_i(en_q[2*p]),       .en_hi_i(en_q[2*p+1]),
            .ctr_lo_i(align_q[2*p]),   .ctr_hi_i(align_q[2*p+1]),
            .per_lo_i(per_q[2*p]),     .per_hi_i(per_q[2*p+1]),
            .dty_lo_i(dty_q[2*p]),     .dty_hi_i(dty_q[2*p+1]),
            .pwm_lo_o(pwm_o[2*p]),     .pwm_hi_o(pwm_o[2*p+1]),
            .cnt_lo_o(cnt_w[2*p]),     .cnt_hi_o(cnt_w[2*p+1])
         );
      end
   endgenerate
endmodule

// File: rtl/pwm_octet_chk.sv
module pwm_octet_chk #(
   parameter int NCH = 8,
   parameter int CW  = 8,
   parameter int AW  = 5
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic           tick_i,
   input logic           wr_en_i,
   input logic [AW-1:0]  wr_addr_i,
   input logic [CW-1:0]  wr_data_i,
   input logic [NCH-1:0] pwm_o,
   input logic [NCH-1:0] en_q,
   input logic [NCH-1:0] fuse_q
);
   import pwm_octet_pkg::*;

   // R1: pins low throughout reset
   always @(posedge clk_i) begin
      if (!rst_ni) assert_reset_quiet_R1: assert (pwm_o == '0);
   end

   // R2: enable byte captures the written data
   assert_enable_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == AW'(ADDR_EN)) |=> (en_q == $past(wr_data_i[NCH-1:0])));

   // R6: no pin is high unless its own enable bit is set
   assert_disabled_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pwm_o & ~en_q) == '0));

   // R10: with no tick and no write, pins hold
   assert_tick_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_en_i) |=> $stable(pwm_o));

   // R7: even pin of a fused pair stays low
   generate
      for (genvar p = 0; p < NCH / 2; p++) begin : g_fuse
         assert_fused_even_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            fuse_q[NCH/2 + p] |-> !pwm_o[2*p]);
      end
   endgenerate
endmodule

bind pwm_octet pwm_octet_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
   .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
   .pwm_o(pwm_o), .en_q(en_q), .fuse_q(fuse_q)
);

// File: tb/pwm_octet_bench.sv
`timescale 1ns/1ps
module pwm_octet_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [4:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [7:0] pwm;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pwm_octet u_pwm_octet (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pwm_o(pwm)
   );

   typedef struct packed {
      int req; int ch; int fuse; int ctr; int per; int duty; int win; int highs;
   } vec_t;

   // window = two whole waveform cycles, highs = expected high ticks in it
   localparam vec_t VECS [9] = '{
      '{3, 0, 0, 0,   8,   3,  16,   6},   // R3 left
      '{5, 5, 0, 0,   7,   0,  14,   0},   // R5 duty zero
      '{5, 3, 0, 0,   4,   9,   8,   8},   // R5 duty above period
      '{4, 4, 0, 1,   6,   2,  24,   6},   // R4 center
      '{5, 6, 0, 1,   5,   5,  20,  20},   // R5 duty equal period, center
      '{4, 1, 0, 1,   1,   1,   4,   4},   // R4 shortest center period
      '{4, 2, 0, 1,   9,   4,  36,  14},   // R4 center
      '{7, 7, 1, 1,   3,   1,  12,   2},   // R7 fused center
      '{7, 3, 1, 0, 258, 129, 516, 258}    // R7 fused left, 16-bit values
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 5'(addr); wr_data = 8'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int addr, output int data);
      rd_addr = 5'(addr);
      #0.5;
      data = int'(rd_data);
   endtask

   task automatic measure(input int ch, input int win, output int highs);
      highs = 0;
      for (int i = 0; i < win; i++) begin
         highs += int'(pwm[ch]);
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected done");
      finish_run();
   end

   initial begin
      int v, h, c0, c1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 pins", int'(pwm), 0);
      rd('h00, v); check("R1 enable", v, 0);
      rd('h01, v); check("R1 align", v, 0);
      rd('h02, v); check("R1 fuse", v, 0);
      rd('h0F, v); check("R1 period7", v, 0);
      rst_n = 1'b1;

      // R2: readback and fusion byte masking
      wr('h01, 'hA5); rd('h01, v); check("R2 align readback", v, 'hA5);
      wr('h02, 'hFF); rd('h02, v); check("R2 fuse low bits", v, 'hF0);
      wr('h12, 'h3C); rd('h12, v); check("R2 duty2 readback", v, 'h3C);

      // table walk
      foreach (VECS[k]) begin
         wr('h00, 0); wr('h02, 0); wr('h01, 0);
         if (VECS[k].fuse != 0) begin
            wr('h08 + VECS[k].ch - 1, VECS[k].per >> 8);
            wr('h10 + VECS[k].ch - 1, VECS[k].duty >> 8);
            wr('h02, 1 << (4 + VECS[k].ch / 2));
         end
         wr('h08 + VECS[k].ch, VECS[k].per & 'hFF);
         wr('h10 + VECS[k].ch, VECS[k].duty & 'hFF);
         wr('h01, VECS[k].ctr << VECS[k].ch);
         wr('h00, 1 << VECS[k].ch);
         measure(VECS[k].ch, VECS[k].win, h);
         check($sformatf("R%0d vector %0d highs", VECS[k].req, k), h, VECS[k].highs);
      end

      // R7 / R8: fused pair 2/3, even pin quiet, counter bytes split
      wr('h00, 0); wr('h02, 0); wr('h01, 0);
      wr('h0A, 1); wr('h0B, 2); wr('h12, 0); wr('h13, 129); wr('h02, 'h20);
      wr('h00, 'h08);
      measure(2, 256, h);
      check("R7 even pin low", h, 0);
      rd('h1A, c0); rd('h1B, c1);
      check("R8 upper byte", c0, 1);
      check("R8 lower byte", c1, 0);

      // R6: disabled channel low with counter 0
      wr('h00, 0);
      check("R6 pins", int'(pwm), 0);
      rd('h1B, v); check("R6 counter", v, 0);

      // R9: duty written mid-period applies at the wrap
      wr('h02, 0); wr('h01, 0); wr('h09, 10); wr('h11, 3);
      wr('h00, 'h02);
      wr('h11, 7);
      measure(1, 8, h);
      check("R9 old duty remainder", h, 1);
      measure(1, 10, h);
      check("R9 new duty next period", h, 7);

      // R10: tick low freezes counter and pin
      tick = 1'b0;
      @(negedge clk);
      rd('h19, c0); v = int'(pwm[1]);
      repeat (5) @(negedge clk);
      rd('h19, c1);
      check("R10 counter held", c1, c0);
      check("R10 pin held", int'(pwm[1]), v);
      tick = 1'b1;

      finish_run();
   end
endmodule